// File: doc/BRIEF.md
# Indirect Address Register Unit

This block keeps a 16-bit pointer into program memory for a small microcontroller core. Software uses the pointer for four jobs. It reads a constant table: the 16-bit word at the pointed address is brought into the data buffer. It saves the pointer to a small address stack and restores it from there. It hands the pointer to the program counter logic as the target of an indirect jump or an indirect subroutine call. It steps the pointer forward by one. The pointer can also be written from the data buffer in one cycle, and its current value is always visible on an output for the data buffer to read.

The core's decoder drives one strobe for each operation. Four strobes change the pointer or the stack: pop, push, load and increment. If more than one of them is asserted, a fixed priority decides which one acts. The other three strobes only use the pointer: table read, jump and call. They may come in the same cycle as an update and always see the value held before that cycle's edge. A parameter sets the top of program memory. Any use of a pointer above that limit is blocked and flagged.

Top module: `arx_unit`

## Requirements
- R1: After a synchronous reset, ar_q is 0000H, sp_q equals the stack depth (8 by default, meaning empty), and stk_ovf, stk_unf, dbuf_valid, pc_req, pmem_rd_en and range_err are all 0.
- R2: An increment adds one to ar_q at the next clock edge, and FFFFH wraps to 0000H.
- R3: A table read with an in-range pointer raises pmem_rd_en in the same cycle, with pmem_addr equal to ar_q. The memory answers on pmem_rdata one edge later. At the edge after that, dbuf_data takes the returned word and dbuf_valid is 1 for that cycle.
- R4: A push with sp_q above 0 lowers sp_q by one and writes ar_q into the entry whose index is the new sp_q. A push with sp_q at 0 leaves sp_q, the stack contents and ar_q unchanged and sets stk_ovf, which stays set until reset.
- R5: A pop with sp_q below the depth copies the entry at index sp_q into ar_q and then raises sp_q by one. A pop with sp_q at the depth leaves ar_q and sp_q unchanged and sets stk_unf, which stays set until reset.
- R6: A jump or call strobe with an in-range pointer raises pc_req in the same cycle with pc_target equal to ar_q. pc_call is 1 only for a call, so the program counter logic knows to save its return address.
- R7: When a table read, jump or call is requested while ar_q is above TOP_ADDR (3FFFH by default), range_err is 1 in that cycle and neither pmem_rd_en nor pc_req is raised. At exactly TOP_ADDR the access goes ahead.
- R8: A load writes load_data into ar_q at the next edge.
- R9: When several update strobes are high together, only one acts, in the order pop, then push, then load, then increment. The others have no effect on ar_q or sp_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_pop | input | 1 | Restore the pointer from the stack |
| op_push | input | 1 | Save the pointer on the stack |
| op_load | input | 1 | Load the pointer from load_data |
| op_inc | input | 1 | Step the pointer by one |
| op_tbl | input | 1 | Table read at the pointer |
| op_br | input | 1 | Indirect jump to the pointer |
| op_call | input | 1 | Indirect call to the pointer |
| load_data | input | 16 | Value from the data buffer |
| ar_q | output | 16 | Current pointer value |
| sp_q | output | 4 | Stack pointer (depth means empty) |
| pmem_addr | output | 16 | Program memory read address |
| pmem_rd_en | output | 1 | Program memory read request |
| pmem_rdata | input | 16 | Program memory word, one cycle after the request |
| dbuf_data | output | 16 | Word fetched by a table read |
| dbuf_valid | output | 1 | One-cycle strobe marking new dbuf_data |
| pc_target | output | 16 | Jump or call target |
| pc_req | output | 1 | Request to load the program counter |
| pc_call | output | 1 | The request is a call |
| range_err | output | 1 | The pointer used is above TOP_ADDR |
| stk_ovf | output | 1 | Sticky push-overflow flag |
| stk_unf | output | 1 | Sticky pop-underflow flag |

## Verification
A wrong pointer value shows on ar_q at the next falling edge. It also shows on pc_target and pmem_addr as soon as the pointer is used. A wrong stack entry stays hidden until a pop brings it back, and from then on every restored pointer differs from the expected one. A wrong stack pointer shows on sp_q at once, and it also moves the points at which stk_ovf and stk_unf fire. A fault in the fetch pipeline moves dbuf_valid off its slot two edges after the read request, or puts the wrong word in dbuf_data.

// File: rtl/arx_pkg.sv
package arx_pkg;
    localparam int ARX_AW = 16;
    typedef logic [ARX_AW-1:0] arx_addr_t;

    typedef enum logic [2:0] {
        ARX_NONE,
        ARX_POP,
        ARX_PUSH,
        ARX_LOAD,
        ARX_INC
    } arx_op_e;

    // strobes that change the pointer or the stack
    typedef struct packed {
        logic pop;
        logic push;
        logic load;
        logic inc;
    } arx_mod_req_t;

    // strobes that only use the pointer
    typedef struct packed {
        logic tbl;
        logic br;
        logic call;
    } arx_use_req_t;

    function automatic arx_op_e arx_pick(arx_mod_req_t r);
        if (r.pop)       return ARX_POP;
        else if (r.push) return ARX_PUSH;
        else if (r.load) return ARX_LOAD;
        else if (r.inc)  return ARX_INC;
        else             return ARX_NONE;
    endfunction

    function automatic logic arx_in_range(arx_addr_t a, arx_addr_t top);
        return a <= top;
    endfunction
endpackage

// File: rtl/arx_op_arb.sv
module arx_op_arb
    import arx_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  arx_mod_req_t req,
    output arx_op_e      op
);
    always_comb op = arx_pick(req);

    assert_prio_pop_R9: assert property (@(posedge clk) disable iff (rst)
        req.pop |-> op == ARX_POP);
    assert_prio_push_R9: assert property (@(posedge clk) disable iff (rst)
        (req.push && !req.pop) |-> op == ARX_PUSH);
    assert_prio_load_R9: assert property (@(posedge clk) disable iff (rst)
        (req.load && !req.pop && !req.push) |-> op == ARX_LOAD);
endmodule

// File: rtl/arx_addr_stack.sv
module arx_addr_stack
    import arx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            do_push,
    input  logic            do_pop,
    input  arx_addr_t       push_data,
    output arx_addr_t       pop_data,
    output logic            pop_ok,
    output logic [SP_W-1:0] sp,
    output logic            ovf,
    output logic            unf
);
    localparam logic [SP_W-1:0] SP_TOP = SP_W'(DEPTH);

    arx_addr_t       ent [DEPTH];
    logic [DEPTH-1:0] wr_en;
    logic            push_ok;
    logic [SP_W-1:0] sp_dec;

    assign push_ok = do_push && (sp != '0);
    assign pop_ok  = do_pop && (sp != SP_TOP);
    assign sp_dec  = sp - SP_W'(1);

    // one write enable per entry, selected by the pre-decremented pointer
    for (genvar i = 0; i < DEPTH; i++) begin : g_wen
        assign wr_en[i] = push_ok && (sp_dec == SP_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_en[i]) ent[i] <= push_data;
        end
    end

    always_comb begin
        pop_data = '0;
        for (int i = 0; i < DEPTH; i++)
            if (sp == SP_W'(i)) pop_data = ent[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= SP_TOP;
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (push_ok)      sp  <= sp_dec;
            else if (pop_ok)  sp  <= sp + SP_W'(1);
            if (do_push && !push_ok) ovf <= 1'b1;
            if (do_pop && !pop_ok)   unf <= 1'b1;
        end
    end

    assert_push_predec_R4: assert property (@(posedge clk) disable iff (rst)
        (do_push && sp != '0) |=> sp == $past(sp) - SP_W'(1));
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_pop_postinc_R5: assert property (@(posedge clk) disable iff (rst)
        (do_pop && sp != SP_TOP) |=> sp == $past(sp) + SP_W'(1));
    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        unf |=> unf);
    assert_sp_bound_R1: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_TOP);
endmodule

// File: rtl/arx_tbl_fetch.sv
module arx_tbl_fetch
    import arx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      issue,
    input  arx_addr_t rdata,
    output arx_addr_t dbuf_data,
    output logic      dbuf_valid
);
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= 1'b0;
            dbuf_valid <= 1'b0;
            dbuf_data  <= '0;
        end else begin
            pend       <= issue;
            dbuf_valid <= pend;
            if (pend) dbuf_data <= rdata;
        end
    end

    assert_fetch_slot_R3: assert property (@(posedge clk) disable iff (rst)
        issue |-> ##2 dbuf_valid);
    assert_fetch_cause_R3: assert property (@(posedge clk) disable iff (rst)
        !issue |-> ##2 !dbuf_valid);
endmodule

// File: rtl/arx_unit.sv
module arx_unit
    import arx_pkg::*;
#(
    parameter arx_addr_t TOP_ADDR  = 16'h3FFF,
    parameter int        STK_DEPTH = 8,
    localparam int       SP_W      = $clog2(STK_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_pop,
    input  logic            op_push,
    input  logic            op_load,
    input  logic            op_inc,
    input  logic            op_tbl,
    input  logic            op_br,
    input  logic            op_call,
    input  logic [15:0]     load_data,
    output logic [15:0]     ar_q,
    output logic [SP_W-1:0] sp_q,
    output logic [15:0]     pmem_addr,
    output logic            pmem_rd_en,
    input  logic [15:0]     pmem_rdata,
    output logic [15:0]     dbuf_data,
    output logic            dbuf_valid,
    output logic [15:0]     pc_target,
    output logic            pc_req,
    output logic            pc_call,
    output logic            range_err,
    output logic            stk_ovf,
    output logic            stk_unf
);
    arx_mod_req_t mod_req;
    arx_use_req_t use_req;
    arx_op_e      op;
    arx_addr_t    pop_data;
    logic         pop_ok;
    logic         addr_ok;

    assign mod_req = '{pop: op_pop, push: op_push, load: op_load, inc: op_inc};
    assign use_req = '{tbl: op_tbl, br: op_br, call: op_call};

    arx_op_arb u_arb (
        .clk (clk),
        .rst (rst),
        .req (mod_req),
        .op  (op)
    );

    arx_addr_stack #(.DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .do_push   (op == ARX_PUSH),
        .do_pop    (op == ARX_POP),
        .push_data (ar_q),
        .pop_data  (pop_data),
        .pop_ok    (pop_ok),
        .sp        (sp_q),
        .ovf       (stk_ovf),
        .unf       (stk_unf)
    );

    // pointer register
    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0;
        end else begin
            unique case (op)
                ARX_POP:  if (pop_ok) ar_q <= pop_data;
                ARX_LOAD: ar_q <= load_data;
                ARX_INC:  ar_q <= ar_q + 16'd1;
                default:  ;
            endcase
        end
    end

    // range guard on every use of the pointer
    assign addr_ok    = arx_in_range(ar_q, TOP_ADDR);
    assign range_err  = (use_req.tbl || use_req.br || use_req.call) && !addr_ok;
    assign pmem_addr  = ar_q;
    assign pmem_rd_en = use_req.tbl && addr_ok;
    assign pc_target  = ar_q;
    assign pc_req     = (use_req.br || use_req.call) && addr_ok;
    assign pc_call    = use_req.call && addr_ok;

    arx_tbl_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .issue      (pmem_rd_en),
        .rdata      (pmem_rdata),
        .dbuf_data  (dbuf_data),
        .dbuf_valid (dbuf_valid)
    );

    assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (op_inc && !op_pop && !op_push && !op_load) |=> ar_q == $past(ar_q) + 16'd1);
    assert_load_R8: assert property (@(posedge clk) disable iff (rst)
        (op_load && !op_pop && !op_push) |=> ar_q == $past(load_data));
    assert_range_block_R7: assert property (@(posedge clk) disable iff (rst)
        (ar_q > TOP_ADDR) |-> (!pmem_rd_en && !pc_req && !pc_call));
    assert_call_implies_req_R6: assert property (@(posedge clk) disable iff (rst)
        pc_call |-> pc_req);
    assert_underflow_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op_pop && sp_q == SP_W'(STK_DEPTH)) |=> ar_q == $past(ar_q));
endmodule

// File: tb/arx_unit_tb_top.sv
`timescale 1ns/1ps
module arx_unit_tb_top;
    localparam logic [15:0] TOP   = 16'h3FFF;
    localparam int          DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_pop = 0, op_push = 0, op_load = 0, op_inc = 0;
    logic        op_tbl = 0, op_br = 0, op_call = 0;
    logic [15:0] load_data = '0;
    logic [15:0] ar_q, pmem_addr, pmem_rdata, dbuf_data, pc_target;
    logic [3:0]  sp_q;
    logic        pmem_rd_en, dbuf_valid, pc_req, pc_call, range_err, stk_ovf, stk_unf;

    int vectors = 0;
    int fails   = 0;

    // expected state
    logic [15:0] e_ar;
    int          e_sp;
    logic [15:0] e_stk [DEPTH];
    logic        e_ovf, e_unf, e_pend, e_vld;
    logic [15:0] e_pdata, e_dbuf;

    always #10 clk = ~clk;

    arx_unit dut_i (
        .clk(clk), .rst(rst),
        .op_pop(op_pop), .op_push(op_push), .op_load(op_load), .op_inc(op_inc),
        .op_tbl(op_tbl), .op_br(op_br), .op_call(op_call),
        .load_data(load_data), .ar_q(ar_q), .sp_q(sp_q),
        .pmem_addr(pmem_addr), .pmem_rd_en(pmem_rd_en), .pmem_rdata(pmem_rdata),
        .dbuf_data(dbuf_data), .dbuf_valid(dbuf_valid),
        .pc_target(pc_target), .pc_req(pc_req), .pc_call(pc_call),
        .range_err(range_err), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    function automatic logic [15:0] memf(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    // synchronous program memory, one cycle of latency
    always_ff @(posedge clk)
        if (pmem_rd_en) pmem_rdata <= memf(pmem_addr);

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        chk("R2/R5/R8/R9 ar_q", ar_q, e_ar);
        chk("R4/R5 sp_q", {12'd0, sp_q}, 16'(e_sp));
        chk("R4 stk_ovf", {15'd0, stk_ovf}, {15'd0, e_ovf});
        chk("R5 stk_unf", {15'd0, stk_unf}, {15'd0, e_unf});
        chk("R3 dbuf_valid", {15'd0, dbuf_valid}, {15'd0, e_vld});
        if (e_vld) chk("R3 dbuf_data", dbuf_data, e_dbuf);
    endtask

    task automatic do_reset();
        rst = 1; {op_pop, op_push, op_load, op_inc, op_tbl, op_br, op_call} = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        e_ar = '0; e_sp = DEPTH; e_ovf = 0; e_unf = 0;
        e_pend = 0; e_vld = 0; e_pdata = '0; e_dbuf = '0;
        for (int i = 0; i < DEPTH; i++) e_stk[i] = '0;
        #2;
        check_regs();
        chk("R1 pc_req", {15'd0, pc_req}, 16'd0);
        chk("R1 pmem_rd_en", {15'd0, pmem_rd_en}, 16'd0);
        chk("R1 range_err", {15'd0, range_err}, 16'd0);
    endtask

    // one cycle: drive at the falling edge, check the combinational outputs,
    // update the model at the rising edge, check the registers at the next fall
    task automatic cyc(logic p, logic u, logic l, logic n, logic t, logic b, logic c,
                       logic [15:0] d);
        logic ok;
        op_pop = p; op_push = u; op_load = l; op_inc = n;
        op_tbl = t; op_br = b; op_call = c; load_data = d;
        #2;
        ok = (e_ar <= TOP);
        chk("R3/R7 pmem_rd_en", {15'd0, pmem_rd_en}, {15'd0, t && ok});
        chk("R6/R7 pc_req", {15'd0, pc_req}, {15'd0, (b || c) && ok});
        chk("R6 pc_call", {15'd0, pc_call}, {15'd0, c && ok});
        chk("R7 range_err", {15'd0, range_err}, {15'd0, (t || b || c) && !ok});
        if (pc_req) chk("R6 pc_target", pc_target, e_ar);
        if (pmem_rd_en) chk("R3 pmem_addr", pmem_addr, e_ar);
        @(posedge clk);
        e_vld = e_pend;
        if (e_pend) e_dbuf = e_pdata;
        e_pend = t && ok;
        e_pdata = memf(e_ar);
        if (p) begin
            if (e_sp == DEPTH) e_unf = 1;
            else begin e_ar = e_stk[e_sp]; e_sp++; end
        end else if (u) begin
            if (e_sp == 0) e_ovf = 1;
            else begin e_sp--; e_stk[e_sp] = e_ar; end
        end else if (l) e_ar = d;
        else if (n) e_ar = e_ar + 16'd1;
        @(negedge clk);
        #2;
        check_regs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();                                      // R1

        // R5: pop on empty stack underflows and keeps ar_q
        cyc(0,0,1,0,0,0,0,16'h1234);
        cyc(1,0,0,0,0,0,0,16'h0);
        // R2: wrap
        cyc(0,0,1,0,0,0,0,16'hFFFF);
        cyc(0,0,0,1,0,0,0,16'h0);
        do_reset();

        // R4: fill the stack, then overflow
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0,0,1,0,0,0,0,16'(16'h0100 + i));
            cyc(0,1,0,0,0,0,0,16'h0);
        end
        cyc(0,0,1,0,0,0,0,16'hBEEF);
        cyc(0,1,0,0,0,0,0,16'h0);                        // R4 overflow
        // R5: drain in reverse order
        for (int i = 0; i < DEPTH; i++) cyc(1,0,0,0,0,0,0,16'h0);
        do_reset();

        // R7: boundary at TOP and TOP+1
        cyc(0,0,1,0,0,0,0,TOP);
        cyc(0,0,0,0,1,0,0,16'h0);
        cyc(0,0,0,0,0,0,1,16'h0);
        cyc(0,0,0,1,0,1,0,16'h0);                        // jump at TOP, then step
        cyc(0,0,0,0,1,1,0,16'h0);                        // blocked at TOP+1
        cyc(0,0,0,0,0,0,1,16'h0);
        // R3: back-to-back table reads while stepping
        cyc(0,0,1,0,0,0,0,16'h0020);
        cyc(0,0,0,1,1,0,0,16'h0);
        cyc(0,0,0,1,1,0,0,16'h0);
        cyc(0,0,0,0,0,0,0,16'h0);
        cyc(0,0,0,0,0,0,0,16'h0);
        // R9: all update strobes together
        cyc(0,1,0,0,0,0,0,16'h0);
        cyc(1,1,1,1,0,0,0,16'h7777);
        cyc(0,1,1,1,0,0,0,16'h0ABC);
        cyc(0,0,1,1,0,0,0,16'h0DEF);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [15:0] d;
            if (k % 600 == 599) do_reset();
            d = ($urandom % 5 == 0) ? 16'($urandom) : 16'($urandom % 32'h4000);
            cyc($urandom % 6 == 0, $urandom % 5 == 0, $urandom % 5 == 0,
                $urandom % 3 == 0, $urandom % 3 == 0, $urandom % 6 == 0,
                $urandom % 6 == 0, d);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule